// File: doc/BRIEF.md
# Guest Event Trap Decider

This unit decides, one event at a time, whether something a guest does must be handed to the hypervisor. When guest entry begins, the hypervisor's intercept settings are written in through a load port in a single cycle: a 16-bit mask for control-register reads, another for control-register writes, two 16-bit masks for debug-register reads and writes, a 32-bit exception mask and a 64-bit general mask. The same load strobe puts the unit in guest mode. A leave strobe returns it to host mode and zeroes every mask.

Each cycle an event code may arrive with a valid strobe and a 64-bit parameter. The code space is divided into fixed ranges. The range a code falls in picks the mask, and the code's offset from the range base picks the bit. The unit registers the decision and raises a single-cycle exit request that carries the code and the parameter. The unit has no back-pressure. An event offered with `ev_valid` high is taken in that cycle, so there is no ready signal, and nothing downstream can stall an exit request. MSR and I/O permission bitmaps are handled by other units.

Top module: `guest_trap_unit`

## Requirements
- R1: While guest mode is clear, `exit_req` stays low whatever events arrive.
- R2: In guest mode, an event whose code lies in CRR_BASE..CRR_BASE+8 (default 0..8) traps exactly when bit (code − CRR_BASE) of the control-read mask is 1.
- R3: In guest mode, codes CRW_BASE..CRW_BASE+8 (default 16..24) trap exactly when bit (code − CRW_BASE) of the control-write mask is 1.
- R4: In guest mode, codes DRR_BASE..DRR_BASE+7 (default 32..39) index the debug-read mask, and codes DRW_BASE..DRW_BASE+7 (default 48..55) index the debug-write mask, each by the offset from its base.
- R5: In guest mode, codes EXC_BASE..EXC_BASE+31 (default 64..95) trap exactly when bit (code − EXC_BASE) of the 32-bit exception mask is 1.
- R6: Any code outside the ranges in R2 to R5 traps in guest mode exactly when it lies in GEN_BASE..GEN_BASE+63 (default 96..159) and bit (code − GEN_BASE) of the general mask is 1. A code below GEN_BASE that falls in none of those ranges never traps, for example 9..15 in the default layout. Neither does a code at or above GEN_BASE+64.
- R7: A cycle with `load_en` high and `leave` low loads all six masks and sets guest mode at the next clock edge. An event in that same cycle is judged with the settings that held before the load.
- R8: A cycle with `leave` high clears guest mode and zeroes every mask at the next edge. `leave` wins over `load_en` in the same cycle.
- R9: `exit_req` rises one clock after a trapping valid event and lasts one cycle for each such event. In that cycle `exit_code` and `exit_info` equal the event's code and parameter. Without a valid event there is no request.
- R10: When `exit_req` is low, `exit_code` and `exit_info` are zero. After reset, guest mode and `exit_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load all masks and enter guest mode |
| ld_cr_rd | input | 16 | Control-register read mask |
| ld_cr_wr | input | 16 | Control-register write mask |
| ld_dr_rd | input | 16 | Debug-register read mask |
| ld_dr_wr | input | 16 | Debug-register write mask |
| ld_exc | input | 32 | Exception mask |
| ld_gen | input | 64 | General intercept mask |
| leave | input | 1 | Return to host mode and zero all masks |
| ev_valid | input | 1 | Event strobe |
| ev_code | input | CODE_W | Event code |
| ev_param | input | INFO_W | Event parameter |
| exit_req | output | 1 | Exit request, one cycle per trapping event |
| exit_code | output | CODE_W | Code of the trapping event |
| exit_info | output | INFO_W | Parameter of the trapping event |
| guest_mode | output | 1 | Guest mode flag |

## Verification
On every cycle, the assertions check the mode rules and the output contract. They confirm that host mode never produces a request, that leave drops guest mode and wins over load, and that a load enters guest mode. They also confirm that a request always follows a valid event and echoes its code, and that the outputs are zero when idle. Whether a particular code maps to the right mask bit can only be shown by the bench's scenarios. These probe the first and last code of every range, the gaps between ranges, codes past the general window, and random masks against a model of the range table.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned CR_W  = 16;
  localparam int unsigned DR_W  = 16;
  localparam int unsigned EXC_W = 32;
  localparam int unsigned GEN_W = 64;
  localparam int unsigned IDX_W = 6;

  typedef enum logic [2:0] {
    CAT_CRR  = 3'd0,
    CAT_CRW  = 3'd1,
    CAT_DRR  = 3'd2,
    CAT_DRW  = 3'd3,
    CAT_EXC  = 3'd4,
    CAT_GEN  = 3'd5,
    CAT_NONE = 3'd6
  } trap_cat_e;

  typedef struct packed {
    logic [CR_W-1:0]  crr;
    logic [CR_W-1:0]  crw;
    logic [DR_W-1:0]  drr;
    logic [DR_W-1:0]  drw;
    logic [EXC_W-1:0] exc;
    logic [GEN_W-1:0] gen;
  } trap_vec_t;
endpackage

// File: rtl/trap_code_decode.sv
module trap_code_decode
  import trap_pkg::*;
#(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned CRR_BASE = 0,
  parameter int unsigned CRW_BASE = 16,
  parameter int unsigned DRR_BASE = 32,
  parameter int unsigned DRW_BASE = 48,
  parameter int unsigned EXC_BASE = 64,
  parameter int unsigned GEN_BASE = 96
) (
  input  logic [CODE_W-1:0] code,
  output trap_cat_e         cat,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned NRNG = 5;
  localparam int unsigned BASES [NRNG] = '{CRR_BASE, CRW_BASE, DRR_BASE, DRW_BASE, EXC_BASE};
  localparam int unsigned SPANS [NRNG] = '{9, 9, 8, 8, EXC_W};

  logic [NRNG-1:0]      hit;
  logic [IDX_W-1:0]     off [NRNG];
  logic [CODE_W-1:0]    gdiff;
  logic                 in_gen;

  for (genvar g = 0; g < NRNG; g++) begin : g_rng
    localparam int unsigned B = BASES[g];
    localparam int unsigned S = SPANS[g];
    logic [CODE_W-1:0] diff;
    assign diff   = code - CODE_W'(B);
    assign hit[g] = (code >= CODE_W'(B)) && (code < CODE_W'(B + S));
    assign off[g] = diff[IDX_W-1:0];
  end

  assign gdiff  = code - CODE_W'(GEN_BASE);
  assign in_gen = (code >= CODE_W'(GEN_BASE)) && (code < CODE_W'(GEN_BASE + GEN_W));

  always_comb begin
    cat = in_gen ? CAT_GEN : CAT_NONE;
    idx = in_gen ? gdiff[IDX_W-1:0] : '0;
    for (int i = NRNG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        cat = trap_cat_e'(i);
        idx = off[i];
      end
    end
  end
endmodule

// File: rtl/trap_vec_regs.sv
module trap_vec_regs
  import trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_en,
  input  logic      leave,
  input  trap_vec_t ld_vec,
  output trap_vec_t vec,
  output logic      guest
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec   <= '0;
      guest <= 1'b0;
    end else if (leave) begin
      vec   <= '0;
      guest <= 1'b0;
    end else if (load_en) begin
      vec   <= ld_vec;
      guest <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_bit_select.sv
module trap_bit_select
  import trap_pkg::*;
(
  input  trap_vec_t        vec,
  input  trap_cat_e        cat,
  input  logic [IDX_W-1:0] idx,
  output logic             hit
);
  always_comb begin
    unique case (cat)
      CAT_CRR: hit = vec.crr[idx[3:0]];
      CAT_CRW: hit = vec.crw[idx[3:0]];
      CAT_DRR: hit = vec.drr[idx[3:0]];
      CAT_DRW: hit = vec.drw[idx[3:0]];
      CAT_EXC: hit = vec.exc[idx[4:0]];
      CAT_GEN: hit = vec.gen[idx];
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/guest_trap_unit.sv
module guest_trap_unit
  import trap_pkg::*;
#(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned INFO_W   = 64,
  parameter int unsigned CRR_BASE = 0,
  parameter int unsigned CRW_BASE = 16,
  parameter int unsigned DRR_BASE = 32,
  parameter int unsigned DRW_BASE = 48,
  parameter int unsigned EXC_BASE = 64,
  parameter int unsigned GEN_BASE = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CR_W-1:0]   ld_cr_rd,
  input  logic [CR_W-1:0]   ld_cr_wr,
  input  logic [DR_W-1:0]   ld_dr_rd,
  input  logic [DR_W-1:0]   ld_dr_wr,
  input  logic [EXC_W-1:0]  ld_exc,
  input  logic [GEN_W-1:0]  ld_gen,
  input  logic              leave,
  input  logic              ev_valid,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [INFO_W-1:0] ev_param,
  output logic              exit_req,
  output logic [CODE_W-1:0] exit_code,
  output logic [INFO_W-1:0] exit_info,
  output logic              guest_mode
);
  trap_vec_t        ld_vec, vec;
  trap_cat_e        cat;
  logic [IDX_W-1:0] idx;
  logic             bit_hit;
  logic             fire;

  assign ld_vec = '{crr: ld_cr_rd, crw: ld_cr_wr, drr: ld_dr_rd,
                    drw: ld_dr_wr, exc: ld_exc, gen: ld_gen};

  trap_vec_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .leave(leave),
    .ld_vec(ld_vec), .vec(vec), .guest(guest_mode)
  );

  trap_code_decode #(
    .CODE_W(CODE_W), .CRR_BASE(CRR_BASE), .CRW_BASE(CRW_BASE),
    .DRR_BASE(DRR_BASE), .DRW_BASE(DRW_BASE), .EXC_BASE(EXC_BASE),
    .GEN_BASE(GEN_BASE)
  ) u_dec (
    .code(ev_code), .cat(cat), .idx(idx)
  );

  trap_bit_select u_sel (
    .vec(vec), .cat(cat), .idx(idx), .hit(bit_hit)
  );

  assign fire = ev_valid && guest_mode && bit_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_req  <= 1'b0;
      exit_code <= '0;
      exit_info <= '0;
    end else begin
      exit_req  <= fire;
      exit_code <= fire ? ev_code  : '0;
      exit_info <= fire ? ev_param : '0;
    end
  end
endmodule

// File: rtl/guest_trap_unit_chk.sv
module guest_trap_unit_chk #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned INFO_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic              leave,
  input logic              ev_valid,
  input logic [CODE_W-1:0] ev_code,
  input logic              exit_req,
  input logic [CODE_W-1:0] exit_code,
  input logic [INFO_W-1:0] exit_info,
  input logic              guest_mode
);
  a_r1_host_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !guest_mode |=> !exit_req);

  a_r8_leave_drops: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> !guest_mode);

  a_r7_load_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !leave) |=> guest_mode);

  a_r9_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> $past(ev_valid));

  a_r9_code_echo: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> exit_code == $past(ev_code));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !exit_req |-> (exit_code == '0 && exit_info == '0));
endmodule

bind guest_trap_unit guest_trap_unit_chk #(.CODE_W(CODE_W), .INFO_W(INFO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .leave(leave),
  .ev_valid(ev_valid), .ev_code(ev_code), .exit_req(exit_req),
  .exit_code(exit_code), .exit_info(exit_info), .guest_mode(guest_mode)
);

// File: tb/sim_guest_trap_unit.sv
module sim_guest_trap_unit;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0, leave = 1'b0, ev_valid = 1'b0;
  logic [15:0] ld_cr_rd = '0, ld_cr_wr = '0, ld_dr_rd = '0, ld_dr_wr = '0;
  logic [31:0] ld_exc = '0;
  logic [63:0] ld_gen = '0;
  logic [CW-1:0] ev_code = '0;
  logic [63:0] ev_param = '0;
  logic exit_req, guest_mode;
  logic [CW-1:0] exit_code;
  logic [63:0] exit_info;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [15:0] m_crr = '0, m_crw = '0, m_drr = '0, m_drw = '0;
  logic [31:0] m_exc = '0;
  logic [63:0] m_gen = '0;
  bit m_guest = 0;

  always #5 clk = ~clk;

  guest_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .ld_cr_rd(ld_cr_rd),
    .ld_cr_wr(ld_cr_wr), .ld_dr_rd(ld_dr_rd), .ld_dr_wr(ld_dr_wr),
    .ld_exc(ld_exc), .ld_gen(ld_gen), .leave(leave), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_param(ev_param), .exit_req(exit_req),
    .exit_code(exit_code), .exit_info(exit_info), .guest_mode(guest_mode)
  );

  function automatic bit mask_bit(int c);
    if (c >= 0  && c <= 8)   return m_crr[c];
    if (c >= 16 && c <= 24)  return m_crw[c-16];
    if (c >= 32 && c <= 39)  return m_drr[c-32];
    if (c >= 48 && c <= 55)  return m_drw[c-48];
    if (c >= 64 && c <= 95)  return m_exc[c-64];
    if (c >= 96 && c <= 159) return m_gen[c-96];
    return 0;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit ld, bit lv, bit v, int code, logic [63:0] prm, string tag);
    bit exp;
    load_en = ld; leave = lv; ev_valid = v;
    ev_code = CW'(code); ev_param = prm;
    exp = v && m_guest && mask_bit(code);
    if (lv) begin
      m_guest = 0; m_crr = '0; m_crw = '0; m_drr = '0; m_drw = '0; m_exc = '0; m_gen = '0;
    end else if (ld) begin
      m_guest = 1; m_crr = ld_cr_rd; m_crw = ld_cr_wr; m_drr = ld_dr_rd;
      m_drw = ld_dr_wr; m_exc = ld_exc; m_gen = ld_gen;
    end
    @(negedge clk);
    load_en = 0; leave = 0; ev_valid = 0;
    chk({tag, " exit_req"}, 64'(exit_req), 64'(exp));
    chk({tag, " exit_code"}, 64'(exit_code), exp ? 64'(code) : 64'd0);
    chk({tag, " exit_info"}, exit_info, exp ? prm : 64'd0);
    chk({tag, " guest_mode"}, 64'(guest_mode), 64'(m_guest));
  endtask

  task automatic set_all(logic [63:0] pat);
    ld_cr_rd = pat[15:0]; ld_cr_wr = pat[15:0]; ld_dr_rd = pat[15:0];
    ld_dr_wr = pat[15:0]; ld_exc = pat[31:0]; ld_gen = pat;
  endtask

  task automatic edge_probe(int code, string tag);
    set_all('1);
    cyc(1, 0, 0, 0, 0, {tag, " load ones"});
    cyc(0, 0, 1, code, 64'hA5A5_0000_0000_0000 | 64'(code), {tag, " set"});
    set_all('0);
    cyc(1, 0, 0, 0, 0, {tag, " load zero"});
    cyc(0, 0, 1, code, 64'h1234, {tag, " clear"});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    chk("R10 reset exit_req", 64'(exit_req), 64'd0);
    chk("R10 reset guest_mode", 64'(guest_mode), 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R1: host mode, valid events on every range
    for (int c = 0; c < 170; c += 7) cyc(0, 0, 1, c, 64'(c), "R1 host");

    // R7: event in the load cycle uses pre-load state
    set_all('1);
    cyc(1, 0, 1, 3, 64'h77, "R7 load same cycle");
    cyc(0, 0, 1, 3, 64'h78, "R7 after load");

    // Range edges
    edge_probe(0,   "R2 first");
    edge_probe(8,   "R2 last");
    edge_probe(16,  "R3 first");
    edge_probe(24,  "R3 last");
    edge_probe(32,  "R4 rd first");
    edge_probe(39,  "R4 rd last");
    edge_probe(48,  "R4 wr first");
    edge_probe(55,  "R4 wr last");
    edge_probe(64,  "R5 first");
    edge_probe(95,  "R5 last");
    edge_probe(96,  "R6 first");
    edge_probe(159, "R6 last");
    edge_probe(9,   "R6 gap low");
    edge_probe(15,  "R6 gap high");
    edge_probe(160, "R6 beyond");

    // R8: leave clears, then ones no longer trap; leave beats load
    set_all('1);
    cyc(1, 0, 0, 0, 0, "R8 load");
    cyc(0, 1, 1, 70, 64'h9, "R8 event in leave cycle");
    cyc(0, 0, 1, 70, 64'h9, "R8 after leave");
    cyc(1, 1, 0, 0, 0, "R8 leave wins");
    cyc(0, 0, 1, 100, 64'h5, "R8 still host");
    cyc(1, 0, 0, 0, 0, "R8 reload");
    cyc(0, 1, 0, 0, 0, "R8 leave");
    set_all('0);
    cyc(1, 0, 0, 0, 0, "R8 enter zero masks");
    cyc(0, 0, 1, 2, 64'h3, "R8 masks zeroed");

    // R9: back-to-back trapping events, one pulse each
    set_all('1);
    cyc(1, 0, 0, 0, 0, "R9 load");
    for (int k = 0; k < 6; k++)
      cyc(0, 0, 1, 96 + k, {$urandom, $urandom}, "R9 back to back");
    cyc(0, 0, 0, 97, 64'hFF, "R9 no valid");

    // Random masks and codes against the model
    for (int n = 0; n < 800; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 8) begin
        ld_cr_rd = 16'($urandom); ld_cr_wr = 16'($urandom);
        ld_dr_rd = 16'($urandom); ld_dr_wr = 16'($urandom);
        ld_exc = $urandom; ld_gen = {$urandom, $urandom};
        cyc(1, 0, $urandom_range(0, 1), $urandom_range(0, 170), {$urandom, $urandom}, "R7 random load");
      end else if (r < 11) begin
        cyc(0, 1, $urandom_range(0, 1), $urandom_range(0, 170), {$urandom, $urandom}, "R8 random leave");
      end else begin
        cyc(0, 0, $urandom_range(0, 3) != 0, $urandom_range(0, 170), {$urandom, $urandom}, "R6 random event");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule